// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits beside a small 8-bit microcontroller core and runs its two low-power states. Software selects a state by writing the power-control register. The register has two mode bits: a light-sleep bit and a deep-sleep bit. From those writes the block drives three registered enables: one for the processor clock, one for the peripheral and interrupt clock, and one for the oscillator.

The two states stop different sets of clocks and wake on different events:

- **Light sleep** stops only the processor clock. It ends on any pending interrupt request.
- **Deep sleep** stops all three enables, including the oscillator. It ends only on a hardware reset, or on an external interrupt pin whose enable bit is set.
  - Because no clock runs in deep sleep, this wake is detected from the level of the pin.
  - After the wake, the oscillator runs alone for `SETTLE_CYCLES` cycles. This lets it settle before the processor and peripheral clocks return together on a register edge.
- In both cases the hardware clears the mode bit when the block wakes.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: A write (`ctl_wr`=1) with `wr_idle`=1 and `wr_pdown`=0, while running, enters light sleep on the next cycle: `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1, `idle_mode`=1.
- R2: In light sleep with `irq_req`=0, the outputs hold at the light-sleep values.
- R3: `irq_req`=1 in light sleep returns the block to running on the next cycle, with all three enables at 1 and `idle_mode` cleared.
- R4: A write with `wr_pdown`=1, while running, enters deep sleep on the next cycle: all three enables at 0 and `pdown_mode`=1.
- R5: A write with both `wr_idle` and `wr_pdown` set enters deep sleep, not light sleep.
- R6: In deep sleep, `irq_req` has no effect, and neither does a high level on any `ext_irq[i]` whose `ext_irq_en[i]` is 0. All enables stay 0.
- R7: A high level on any `ext_irq[i]` with `ext_irq_en[i]`=1, seen in deep sleep, gives the following sequence:
  - `osc_en` rises on the next cycle, with the other enables still at 0 and `pdown_mode` still set.
  - Exactly `SETTLE_CYCLES` cycles after `osc_en` rises, `cpu_clk_en` and `per_clk_en` rise and `pdown_mode` clears.
- R8: A synchronous `rst`=1 from any state gives the following outputs on the next cycle: all enables at 1, `idle_mode`=0 and `pdown_mode`=0.
- R9: Register writes are ignored unless the block is running, and a write with neither mode bit set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ctl_wr | input | 1 | Power-control register write strobe |
| wr_idle | input | 1 | Light-sleep mode bit of the written value |
| wr_pdown | input | 1 | Deep-sleep mode bit of the written value |
| irq_req | input | 1 | Any interrupt request pending |
| ext_irq | input | N_EXT | External interrupt pin levels, active high |
| ext_irq_en | input | N_EXT | Per-pin enable for external interrupts |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| idle_mode | output | 1 | Light-sleep mode bit readback |
| pdown_mode | output | 1 | Deep-sleep mode bit readback |

## Verification
Directed sequences cover the following cases:
- each mode entry, including the simultaneous write of both bits;
- each mode exit;
- resets from both sleep states;
- writes issued while asleep.

These cases separate the two wake rules: the same interrupt request that ends light sleep must leave deep sleep untouched. Random deep-sleep episodes then mix pin levels, pin enables and unrelated requests. They show that only an enabled high pin wakes the block, and that the settle window lasts exactly the set number of cycles whichever pin caused the wake.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_PDOWN  = 2'd2,
    ST_SETTLE = 2'd3
  } lpm_state_t;
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int N_EXT = 2
) (
  input  logic             irq_req,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_irq_en,
  output logic             idle_wake,
  output logic             pdown_wake
);
  logic [N_EXT-1:0] gated;

  // Level-based, clock-free qualification of each external pin.
  for (genvar i = 0; i < N_EXT; i++) begin : g_pin
    assign gated[i] = ext_irq[i] & ext_irq_en[i];
  end

  assign idle_wake  = irq_req;
  assign pdown_wake = |gated;
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start) begin
      cnt_q    <= LOAD;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign done = active_q && (cnt_q == '0);
endmodule

// File: rtl/lpm_enable_gen.sv
module lpm_enable_gen
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lpm_state_t state_d,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       idle_mode,
  output logic       pdown_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      idle_mode  <= 1'b0;
      pdown_mode <= 1'b0;
    end else begin
      cpu_clk_en <= (state_d == ST_RUN);
      per_clk_en <= (state_d == ST_RUN) || (state_d == ST_IDLE);
      osc_en     <= (state_d != ST_PDOWN);
      idle_mode  <= (state_d == ST_IDLE);
      pdown_mode <= (state_d == ST_PDOWN) || (state_d == ST_SETTLE);
    end
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int N_EXT         = 2,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             wr_idle,
  input  logic             wr_pdown,
  input  logic             irq_req,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_irq_en,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             idle_mode,
  output logic             pdown_mode
);
  lpm_state_t state_q, state_d;
  logic idle_wake, pdown_wake, settle_start, settle_done;

  lpm_wake_detect #(.N_EXT(N_EXT)) wake_i (
    .irq_req    (irq_req),
    .ext_irq    (ext_irq),
    .ext_irq_en (ext_irq_en),
    .idle_wake  (idle_wake),
    .pdown_wake (pdown_wake)
  );

  assign settle_start = (state_q == ST_PDOWN) && pdown_wake;

  lpm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .start (settle_start),
    .done  (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (ctl_wr && wr_pdown)     state_d = ST_PDOWN;  // deep sleep wins
        else if (ctl_wr && wr_idle) state_d = ST_IDLE;
      end
      ST_IDLE:   if (idle_wake)   state_d = ST_RUN;
      ST_PDOWN:  if (pdown_wake)  state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_RUN;
      default:                    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  lpm_enable_gen en_i (
    .clk        (clk),
    .rst        (rst),
    .state_d    (state_d),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .idle_mode  (idle_mode),
    .pdown_mode (pdown_mode)
  );
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
  parameter int N_EXT         = 2,
  parameter int SETTLE_CYCLES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic             wr_idle,
  input logic             wr_pdown,
  input logic             irq_req,
  input logic [N_EXT-1:0] ext_irq,
  input logic [N_EXT-1:0] ext_irq_en,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             osc_en,
  input logic             idle_mode,
  input logic             pdown_mode
);
  localparam int SC_W = $clog2(SETTLE_CYCLES + 2) + 1;
  logic [SC_W-1:0] settle_cnt;
  logic            running;

  assign running = cpu_clk_en && !idle_mode && !pdown_mode;

  always_ff @(posedge clk) begin
    if (rst)                                    settle_cnt <= '0;
    else if (osc_en && !cpu_clk_en && !per_clk_en) settle_cnt <= settle_cnt + 1'b1;
    else                                        settle_cnt <= '0;
  end

  a_r1_idle_entry: assert property (@(posedge clk) disable iff (rst)
    running && ctl_wr && wr_idle && !wr_pdown |=>
      idle_mode && !cpu_clk_en && per_clk_en && osc_en);

  a_r3_idle_wake: assert property (@(posedge clk) disable iff (rst)
    idle_mode && irq_req |=> cpu_clk_en && !idle_mode);

  a_r5_pdown_priority: assert property (@(posedge clk) disable iff (rst)
    running && ctl_wr && wr_pdown |=>
      pdown_mode && !idle_mode && !osc_en && !cpu_clk_en && !per_clk_en);

  a_r6_pdown_hold: assert property (@(posedge clk) disable iff (rst)
    pdown_mode && !osc_en && ((ext_irq & ext_irq_en) == '0) |=>
      !osc_en && !cpu_clk_en && !per_clk_en);

  a_r7_settle_len: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en) && !$past(per_clk_en) && !$past(rst) |->
      settle_cnt == SC_W'(SETTLE_CYCLES));

  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> cpu_clk_en && per_clk_en && osc_en && !idle_mode && !pdown_mode);
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(
  .N_EXT(N_EXT), .SETTLE_CYCLES(SETTLE_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wr_idle(wr_idle), .wr_pdown(wr_pdown),
  .irq_req(irq_req), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
  .idle_mode(idle_mode), .pdown_mode(pdown_mode)
);

// File: tb/lpm_clk_ctrl_tb_top.sv
module lpm_clk_ctrl_tb_top;
  localparam int NE = 2;
  localparam int SC = 5;
  // output packing {cpu, per, osc, idle, pdown}
  localparam logic [4:0] O_RUN    = 5'b11100;
  localparam logic [4:0] O_IDLE   = 5'b01110;
  localparam logic [4:0] O_PDOWN  = 5'b00001;
  localparam logic [4:0] O_SETTLE = 5'b00101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 1'b0, wr_idle = 1'b0, wr_pdown = 1'b0, irq_req = 1'b0;
  logic [NE-1:0] ext_irq = '0, ext_irq_en = '0;
  logic cpu_clk_en, per_clk_en, osc_en, idle_mode, pdown_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpm_clk_ctrl #(.N_EXT(NE), .SETTLE_CYCLES(SC)) dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wr_idle(wr_idle), .wr_pdown(wr_pdown),
    .irq_req(irq_req), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .idle_mode(idle_mode), .pdown_mode(pdown_mode)
  );

  function automatic logic exp_wake(logic [NE-1:0] lv, logic [NE-1:0] en);
    return |(lv & en);
  endfunction

  function automatic logic [4:0] outs();
    return {cpu_clk_en, per_clk_en, osc_en, idle_mode, pdown_mode};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [4:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", req, outs(), exp);
    end
  endtask

  task automatic wr(logic i, logic p);
    ctl_wr = 1'b1; wr_idle = i; wr_pdown = p;
    tick();
    ctl_wr = 1'b0; wr_idle = 1'b0; wr_pdown = 1'b0;
  endtask

  task automatic settle_run(string req);
    for (int k = 0; k < SC; k++) begin
      chk(req, O_SETTLE);
      tick();
    end
    chk(req, O_RUN);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: timeout actual 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); tick();
    rst = 1'b0;
    chk("R8 reset state", O_RUN);

    wr(1'b0, 1'b0);
    chk("R9 empty write", O_RUN);

    wr(1'b1, 1'b0);
    chk("R1 idle entry", O_IDLE);
    repeat (3) tick();
    chk("R2 idle hold", O_IDLE);
    wr(1'b0, 1'b1);
    chk("R9 write in idle ignored", O_IDLE);
    irq_req = 1'b1; tick(); irq_req = 1'b0;
    chk("R3 idle wake", O_RUN);

    wr(1'b1, 1'b1);
    chk("R5 both bits", O_PDOWN);
    irq_req = 1'b1; ext_irq = 2'b11; ext_irq_en = 2'b00;
    repeat (3) tick();
    chk("R6 pdown ignores", O_PDOWN);
    wr(1'b1, 1'b0);
    chk("R9 write in pdown ignored", O_PDOWN);
    irq_req = 1'b0; ext_irq = 2'b01; ext_irq_en = 2'b01;
    tick(); ext_irq = '0;
    settle_run("R7 settle ext0");

    wr(1'b0, 1'b1);
    chk("R4 pdown entry", O_PDOWN);
    ext_irq = 2'b10; ext_irq_en = 2'b10;
    tick(); ext_irq = '0;
    settle_run("R7 settle ext1");

    wr(1'b0, 1'b1);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R8 reset from pdown", O_RUN);
    wr(1'b1, 1'b0);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R8 reset from idle", O_RUN);

    for (int it = 0; it < 40; it++) begin
      logic woke;
      wr(1'b1, 1'b1);
      chk("R5 random entry", O_PDOWN);
      woke = 1'b0;
      for (int c = 0; c < 8 && !woke; c++) begin
        ext_irq    = NE'($urandom);
        ext_irq_en = NE'($urandom);
        irq_req    = 1'($urandom);
        woke = exp_wake(ext_irq, ext_irq_en);
        tick();
        ext_irq = '0; irq_req = 1'b0;
        if (!woke) chk("R6 random hold", O_PDOWN);
      end
      if (woke) settle_run("R7 random wake");
      else begin
        ext_irq = 2'b01; ext_irq_en = 2'b01;
        tick(); ext_irq = '0;
        settle_run("R7 forced wake");
      end
    end

    finish_run();
  end
endmodule